// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block chooses the one interrupt that a 16550-style UART reports at a given time. On every clock it looks at the pending sources and picks the most urgent enabled one:

- line errors
- receive timeout
- received data
- transmitter holding register empty
- modem line changes

It publishes that choice as an identification byte and drives a single interrupt line. The block owns the interrupt enable register and a hidden "holding register empty" pending flag. The surrounding UART supplies the line status byte, the receive FIFO fill count and trigger level, the FIFO enable, the timeout flag and the modem delta bits.

The bus decoder supplies four single-cycle strobes:

- write of the enable register
- write of transmit data
- read of the identification register
- a level that is high while the holding register is empty

The bus decoder samples the identification byte and the interrupt line from the outputs. Both are registered, so they follow their inputs one clock edge later.

Top module: `uart_irq_id`

## Requirements
- R1: While rst_ni is low, iir_o reads 0x01, irq_o is 0 and ier_o is 0x00.
- R2: The low nibble of iir_o holds the code of the highest-priority active source. The order, from most to least urgent, is: line status 0x6, receive timeout 0xC, received data 0x4, holding register empty 0x2, modem status 0x0. When no source is active the nibble is 0x1.
- R3: The line status source is active when enable bit 2 is set and any of lsr_i bits 1 to 4 (mask 0x1E) is set. lsr_i bit 0 and bits 5 to 7 never raise it.
- R4: The receive timeout source is active when timeout_pend_i is high and enable bit 0 is set. It has no enable of its own.
- R5: The received data source needs enable bit 0 and lsr_i bit 0 (data ready). With fifo_en_i low nothing more is needed. With fifo_en_i high, rx_count_i must also be at least rx_trig_i.
- R6: The hidden pending flag is set on a low-to-high change of thr_empty_i. While the flag is set and enable bit 1 is set, the holding register empty source is active.
- R7: An ier_wr_i pulse loads ier_wdata_i[3:0] into the enable register, and ier_o[7:4] always reads 0. If thr_empty_i is high during that pulse, the pending flag is set.
- R8: A pulse on iir_rd_i or thr_wr_i clears the pending flag. A clear wins over a set in the same cycle.
- R9: iir_o[7:6] reads 2'b11 when fifo_en_i is high and 2'b00 otherwise. iir_o[5:4] is always 0.
- R10: irq_o is 1 exactly when iir_o[3:0] is not 0x1.
- R11: iir_o, irq_o and ier_o are updated on the edge that samples their inputs. That includes the pending flag and enable values written on that same edge. iir_o sampled during a read pulse is therefore the value from before the read.
- R12: The modem status source is active when enable bit 3 is set and any msr_delta_i bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_wr_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 8 | Enable register write data |
| thr_wr_i | input | 1 | Transmit data write strobe |
| iir_rd_i | input | 1 | Identification register read strobe |
| thr_empty_i | input | 1 | Holding register empty level |
| lsr_i | input | 8 | Line status byte (bit 0 data ready, bits 1-4 errors/break) |
| timeout_pend_i | input | 1 | Receive character timeout pending |
| fifo_en_i | input | 1 | FIFO mode enabled |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| rx_trig_i | input | CNT_W | Receive FIFO trigger level |
| msr_delta_i | input | 4 | Modem status delta bits |
| ier_o | output | 8 | Enable register value |
| iir_o | output | 8 | Identification register value |
| irq_o | output | 1 | Interrupt request |

## Verification
A directed walk first enables all sources and raises them together. It then removes them one at a time, so that each step shows whether the next lower code appears; a wrong priority order shows up at one particular step.

Single-source cases separate the near misses. One case sets only the data-ready and upper line status bits, which must not look like an error. Another raises the timeout with enable bit 0 clear. The FIFO count is set to one below the trigger level and then to exactly the trigger level. A read and a transmit-empty edge arrive in the same cycle.

A seeded random phase then varies every input, including strobe collisions and FIFO on and off. Each cycle is compared with a bench model of the pending flag and the priority chain.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [3:0] {
    IID_MODEM   = 4'h0,
    IID_NONE    = 4'h1,
    IID_THRE    = 4'h2,
    IID_RXDATA  = 4'h4,
    IID_LINE    = 4'h6,
    IID_TIMEOUT = 4'hC
  } iid_e;

  localparam int unsigned IER_W = 4;
  localparam int unsigned MSR_W = 4;
  localparam logic [7:0] LSR_ERR_MASK = 8'h1E;

  // enable bit positions
  localparam int unsigned EN_RX  = 0;
  localparam int unsigned EN_TX  = 1;
  localparam int unsigned EN_LS  = 2;
  localparam int unsigned EN_MS  = 3;
endpackage

// File: rtl/uart_ier_reg.sv
module uart_ier_reg
  import uart_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [7:0]       wdata_i,
  output logic [IER_W-1:0] ier_d_o,
  output logic [IER_W-1:0] ier_q_o
);
  logic [IER_W-1:0] ier_q;

  assign ier_d_o = wr_i ? wdata_i[IER_W-1:0] : ier_q;
  assign ier_q_o = ier_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ier_q <= '0;
    else         ier_q <= ier_d_o;
  end
endmodule

// File: rtl/uart_thre_pend.sv
module uart_thre_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic thr_empty_i,
  input  logic ier_wr_i,
  input  logic thr_wr_i,
  input  logic iir_rd_i,
  output logic pend_d_o
);
  logic pend_q;
  logic empty_q;
  logic set_ev;
  logic clr_ev;

  // empty_q resets high: the holding register is empty out of reset, no edge
  assign set_ev   = (thr_empty_i & ~empty_q) | (ier_wr_i & thr_empty_i);
  assign clr_ev   = iir_rd_i | thr_wr_i;
  assign pend_d_o = clr_ev ? 1'b0 : (set_ev ? 1'b1 : pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      pend_q  <= pend_d_o;
      empty_q <= thr_empty_i;
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic [IER_W-1:0] ier_i,
  input  logic [7:0]       lsr_i,
  input  logic             timeout_i,
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic [MSR_W-1:0] msr_delta_i,
  input  logic             thre_pend_i,
  output iid_e             code_o
);
  localparam int unsigned NSRC = 5;

  logic [NSRC-1:0] act;
  iid_e            code_tab [NSRC];
  logic            rx_lvl_ok;

  assign rx_lvl_ok = ~fifo_en_i | (rx_count_i >= rx_trig_i);

  // index 0 is most urgent
  assign act[0] = ier_i[EN_LS] & |(lsr_i & LSR_ERR_MASK);
  assign act[1] = ier_i[EN_RX] & timeout_i;
  assign act[2] = ier_i[EN_RX] & lsr_i[0] & rx_lvl_ok;
  assign act[3] = ier_i[EN_TX] & thre_pend_i;
  assign act[4] = ier_i[EN_MS] & |msr_delta_i;

  assign code_tab[0] = IID_LINE;
  assign code_tab[1] = IID_TIMEOUT;
  assign code_tab[2] = IID_RXDATA;
  assign code_tab[3] = IID_THRE;
  assign code_tab[4] = IID_MODEM;

  always_comb begin
    code_o = IID_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act[i]) code_o = code_tab[i];
    end
  end
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ier_wr_i,
  input  logic [7:0]       ier_wdata_i,
  input  logic             thr_wr_i,
  input  logic             iir_rd_i,
  input  logic             thr_empty_i,
  input  logic [7:0]       lsr_i,
  input  logic             timeout_pend_i,
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic [3:0]       msr_delta_i,
  output logic [7:0]       ier_o,
  output logic [7:0]       iir_o,
  output logic             irq_o
);
  logic [IER_W-1:0] ier_d;
  logic [IER_W-1:0] ier_q;
  logic             pend_d;
  iid_e             code_d;
  logic [7:0]       iir_q;
  logic             irq_q;

  uart_ier_reg u_ier (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ier_wr_i),
    .wdata_i (ier_wdata_i),
    .ier_d_o (ier_d),
    .ier_q_o (ier_q)
  );

  uart_thre_pend u_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .thr_empty_i (thr_empty_i),
    .ier_wr_i    (ier_wr_i),
    .thr_wr_i    (thr_wr_i),
    .iir_rd_i    (iir_rd_i),
    .pend_d_o    (pend_d)
  );

  // evaluate against post-edge enable and flag so a read clears in one step
  uart_irq_prio #(.CNT_W(CNT_W)) u_prio (
    .ier_i       (ier_d),
    .lsr_i       (lsr_i),
    .timeout_i   (timeout_pend_i),
    .fifo_en_i   (fifo_en_i),
    .rx_count_i  (rx_count_i),
    .rx_trig_i   (rx_trig_i),
    .msr_delta_i (msr_delta_i),
    .thre_pend_i (pend_d),
    .code_o      (code_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iir_q <= {4'h0, IID_NONE};
      irq_q <= 1'b0;
    end else begin
      iir_q <= {{2{fifo_en_i}}, 2'b00, code_d};
      irq_q <= (code_d != IID_NONE);
    end
  end

  assign iir_o = iir_q;
  assign irq_o = irq_q;
  assign ier_o = {{(8 - IER_W){1'b0}}, ier_q};
endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ier_wr_i,
  input logic             thr_wr_i,
  input logic             iir_rd_i,
  input logic [7:0]       lsr_i,
  input logic             timeout_pend_i,
  input logic             fifo_en_i,
  input logic [3:0]       msr_delta_i,
  input logic [CNT_W-1:0] rx_count_i,
  input logic [7:0]       ier_o,
  input logic [7:0]       iir_o,
  input logic             irq_o
);
  assert_irq_line_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (iir_o[3:0] != 4'h1));

  assert_line_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_o[2] && !ier_wr_i && (|lsr_i[4:1])) |=> iir_o[3:0] == 4'h6);

  assert_timeout_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ier_o[0] && !ier_wr_i) |=> (iir_o[3:0] != 4'hC && iir_o[3:0] != 4'h4));

  assert_read_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i || thr_wr_i) |=> iir_o[3:0] != 4'h2);

  assert_fifo_bits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (iir_o[7:6] == {2{$past(fifo_en_i)}} && iir_o[5:4] == 2'b00));

  assert_ier_upper_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_o[7:4] == 4'h0);

  assert_code_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_o[3:0] == 4'h0 || iir_o[3:0] == 4'h1 || iir_o[3:0] == 4'h2 ||
     iir_o[3:0] == 4'h4 || iir_o[3:0] == 4'h6 || iir_o[3:0] == 4'hC));

  assert_modem_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_o[3] && !ier_wr_i && (|msr_delta_i)) |=> irq_o);
endmodule

bind uart_irq_id uart_irq_id_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ier_wr_i       (ier_wr_i),
  .thr_wr_i       (thr_wr_i),
  .iir_rd_i       (iir_rd_i),
  .lsr_i          (lsr_i),
  .timeout_pend_i (timeout_pend_i),
  .fifo_en_i      (fifo_en_i),
  .msr_delta_i    (msr_delta_i),
  .rx_count_i     (rx_count_i),
  .ier_o          (ier_o),
  .iir_o          (iir_o),
  .irq_o          (irq_o)
);

// File: tb/sim_uart_irq_id.sv
module sim_uart_irq_id;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 5;
  localparam int N_RAND = 3000;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             ier_wr_i = 1'b0;
  logic [7:0]       ier_wdata_i = 8'h00;
  logic             thr_wr_i = 1'b0;
  logic             iir_rd_i = 1'b0;
  logic             thr_empty_i = 1'b1;
  logic [7:0]       lsr_i = 8'h00;
  logic             timeout_pend_i = 1'b0;
  logic             fifo_en_i = 1'b0;
  logic [CNT_W-1:0] rx_count_i = '0;
  logic [CNT_W-1:0] rx_trig_i = '0;
  logic [3:0]       msr_delta_i = 4'h0;
  logic [7:0]       ier_o;
  logic [7:0]       iir_o;
  logic             irq_o;

  int n_tests = 0;
  int n_fail = 0;

  logic [3:0] m_ier = 4'h0;
  logic       m_pend = 1'b0;
  logic       m_prev = 1'b1;
  logic [7:0] e_iir = 8'h01;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  uart_irq_id #(.CNT_W(CNT_W)) u0 (.*);

  function automatic logic [3:0] exp_code(input logic [3:0] en, input logic pend);
    if (en[2] && (lsr_i[1] || lsr_i[2] || lsr_i[3] || lsr_i[4])) return 4'h6;
    if (en[0] && timeout_pend_i) return 4'hC;
    if (en[0] && lsr_i[0] && (!fifo_en_i || rx_count_i >= rx_trig_i)) return 4'h4;
    if (en[1] && pend) return 4'h2;
    if (en[3] && msr_delta_i != 4'h0) return 4'h0;
    return 4'h1;
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'h6: return "R3";
      4'hC: return "R4";
      4'h4: return "R5";
      4'h2: return "R6";
      4'h0: return "R12";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // update model for the coming edge, then sample after it
  task automatic step();
    logic set_ev, clr_ev;
    set_ev = (thr_empty_i && !m_prev) || (ier_wr_i && thr_empty_i);
    clr_ev = iir_rd_i || thr_wr_i;
    if (clr_ev) m_pend = 1'b0;
    else if (set_ev) m_pend = 1'b1;
    m_prev = thr_empty_i;
    if (ier_wr_i) m_ier = ier_wdata_i[3:0];
    e_iir = {fifo_en_i, fifo_en_i, 2'b00, exp_code(m_ier, m_pend)};
    @(posedge clk_i);
    @(negedge clk_i);
    ier_wr_i = 1'b0;
    thr_wr_i = 1'b0;
    iir_rd_i = 1'b0;
  endtask

  task automatic dstep(input string tag, input logic [7:0] exp_iir);
    step();
    check(tag, iir_o, exp_iir);
    check("R10", {7'b0, irq_o}, {7'b0, exp_iir[3:0] != 4'h1});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk_i);
    check("R1", iir_o, 8'h01);
    check("R1", {7'b0, irq_o}, 8'h00);
    check("R1", ier_o, 8'h00);
    rst_ni = 1'b1;
    dstep("R1", 8'h01);

    // R7: upper enable bits dropped, write while empty sets flag
    ier_wr_i = 1'b1; ier_wdata_i = 8'hFF;
    dstep("R7", 8'h02);
    check("R7", ier_o, 8'h0F);
    // R8: read clears
    iir_rd_i = 1'b1;
    dstep("R8", 8'h01);
    // R3: data ready and upper bits do not raise line status
    ier_wr_i = 1'b1; ier_wdata_i = 8'h04; lsr_i = 8'hE1;
    dstep("R3", 8'h01);
    lsr_i = 8'h10;
    dstep("R3", 8'h06);
    // R2: peel sources off one by one
    ier_wr_i = 1'b1; ier_wdata_i = 8'h0F; lsr_i = 8'h02; timeout_pend_i = 1'b1; msr_delta_i = 4'h1;
    dstep("R2", 8'h06);
    lsr_i = 8'h01;
    dstep("R2", 8'h0C);
    timeout_pend_i = 1'b0;
    dstep("R2", 8'h04);
    lsr_i = 8'h00;
    dstep("R2", 8'h02);
    iir_rd_i = 1'b1;
    dstep("R2", 8'h00);
    msr_delta_i = 4'h0;
    dstep("R2", 8'h01);
    // R4: timeout masked by enable bit 0
    ier_wr_i = 1'b1; ier_wdata_i = 8'h0C; thr_empty_i = 1'b0; timeout_pend_i = 1'b1; lsr_i = 8'h01;
    dstep("R4", 8'h01);
    ier_wr_i = 1'b1; ier_wdata_i = 8'h0D;
    dstep("R4", 8'h0C);
    // R6: empty edge sets flag
    ier_wr_i = 1'b1; ier_wdata_i = 8'h02; timeout_pend_i = 1'b0; lsr_i = 8'h00;
    dstep("R6", 8'h01);
    thr_empty_i = 1'b1;
    dstep("R6", 8'h02);
    thr_wr_i = 1'b1; thr_empty_i = 1'b0;
    dstep("R8", 8'h01);
    // R8: clear wins over set
    thr_empty_i = 1'b1; iir_rd_i = 1'b1;
    dstep("R8", 8'h01);
    ier_wr_i = 1'b1; ier_wdata_i = 8'h02; iir_rd_i = 1'b1;
    dstep("R8", 8'h01);
    // R5 / R9: trigger level boundary
    ier_wr_i = 1'b1; ier_wdata_i = 8'h01; fifo_en_i = 1'b1; lsr_i = 8'h01;
    rx_count_i = 5'd3; rx_trig_i = 5'd4;
    dstep("R9", 8'hC1);
    rx_count_i = 5'd4;
    dstep("R5", 8'hC4);
    fifo_en_i = 1'b0; rx_count_i = 5'd0;
    dstep("R5", 8'h04);
    // R12: modem deltas
    ier_wr_i = 1'b1; ier_wdata_i = 8'h08; lsr_i = 8'h00; msr_delta_i = 4'b0100;
    dstep("R12", 8'h00);
    msr_delta_i = 4'h0;
    dstep("R12", 8'h01);

    // R11: random phase compared against the model each cycle
    for (int i = 0; i < N_RAND; i++) begin
      ier_wr_i       = ($urandom_range(5) == 0);
      ier_wdata_i    = 8'($urandom);
      thr_wr_i       = ($urandom_range(7) == 0);
      iir_rd_i       = ($urandom_range(7) == 0);
      if ($urandom_range(3) == 0) thr_empty_i = ~thr_empty_i;
      lsr_i          = ($urandom_range(3) == 0) ? 8'($urandom) : {7'($urandom) & 7'h70, 1'($urandom)};
      timeout_pend_i = ($urandom_range(3) == 0);
      fifo_en_i      = 1'($urandom);
      rx_count_i     = CNT_W'($urandom_range(16));
      rx_trig_i      = CNT_W'($urandom_range(16));
      msr_delta_i    = ($urandom_range(3) == 0) ? 4'($urandom) : 4'h0;
      step();
      check(tag_of(e_iir[3:0]), iir_o, e_iir);
      check("R10", {7'b0, irq_o}, {7'b0, e_iir[3:0] != 4'h1});
      check("R11", ier_o, {4'h0, m_ier});
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule